// File: doc/BRIEF.md
# Masked Pin Function and Pull Register File

This block holds, for several GPIO banks, a 2-bit function code and a pull-disable bit for every pin, and drives them straight to the pad logic. Software reaches the storage through a simple memory-mapped port: a write presents an address and a 32-bit word, and the read data for the current address is always available combinationally.

Every 32-bit write carries its own bit-enable mask. The upper half-word selects which bits of the lower half-word are written, one enable per bit. A single pin's field can therefore be changed in one write with no read-modify-write, and neighbouring fields stay as they were. The mux region and the pull region are decoded separately. The pull region's base and per-bank stride come from a layout parameter.

Top module: `pinmux_pull_regs`

## Requirements
- R1: On a write that hits a register, stored bit n (n = 0..15) takes wrData[n] when wrData[n+16] is 1 and keeps its old value when wrData[n+16] is 0.
- R2: The 2-bit function code of pin p in bank b is stored at address MUX_BASE + b*0x10 + (p/8)*4, in bits [2*(p%8)+1 : 2*(p%8)]. It drives muxSel[(b*PINS_PER_BANK+p)*2 +: 2]. With the defaults, MUX_BASE is 0x0A8.
- R3: The pull-disable bit of pin p in bank b is stored at address pullBase + b*pullStride + (p/16)*4, in bit p%16. It drives pullOff[b*PINS_PER_BANK+p]. A value of 1 disables the pulls and a value of 0 applies the pad's default pull.
- R4: With PULL_LAYOUT = 0 the pull region has pullBase 0x118 and pullStride 8. With PULL_LAYOUT = 1 it has pullBase 0x164 and pullStride 16, and the word slots of a bank that lie beyond PINS_PER_BANK/16 words are outside the region.
- R5: A read of a register returns 0 in bits [31:16] and the stored value in bits [15:0].
- R6: After reset every function code is 0, which selects the GPIO function, and every pull bit is 0, which applies the default pull.
- R7: A write to an address outside both regions changes no stored bit, and a read from such an address returns 0.
- R8: A write updates the stored value and the pad outputs at the clock edge where wrEn is sampled high. Before that edge the outputs keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (12) | Byte address. Bits [1:0] are ignored. |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| wrData | input | 32 | Bits [31:16] are the bit-enable mask; bits [15:0] are the value |
| rdData | output | 32 | Combinational read data for addr |
| muxSel | output | NUM_BANKS*PINS_PER_BANK*2 (256) | Function code of every pin |
| pullOff | output | NUM_BANKS*PINS_PER_BANK (128) | Pull-disable bit of every pin |

## Verification
The embedded assertions check the following on every cycle:
- a written word changes only in its enabled bits, and those bits take the written value;
- a word that is not addressed by a write stays stable;
- the mux and pull decodes never both hit at once;
- the upper half of the read data is zero, and a miss reads as zero.

Only the directed scenarios can show the things that need an independent reference:
- that each address lands on the intended pin's bits at the pad outputs;
- that the two pull layouts place their banks at the right bases and strides, with the unused slots ignored;
- the reset values;
- the exact cycle in which an output changes.

// File: rtl/pinregs_pkg.sv
package pinregs_pkg;
  localparam int IDX_W = 8;

  // Decoded strobes handed from the address decode to the storage datapath
  typedef struct packed {
    logic             wrMux;
    logic             wrPull;
    logic             rdMux;
    logic             rdPull;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;
endpackage

// File: rtl/pinregs_decode.sv
module pinregs_decode
  import pinregs_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_BANKS   = 4,
  parameter int MUX_WORDS   = 4,
  parameter int PULL_WORDS  = 2,
  parameter int MUX_BASE    = 'h0A8,
  parameter int PULL_LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output regStrobe_t        strb
);
  localparam int PULL_BASE   = (PULL_LAYOUT == 0) ? 'h118 : 'h164;
  localparam int PULL_STRIDE = (PULL_LAYOUT == 0) ? 8 : 16;
  localparam int STRIDE_SH   = $clog2(PULL_STRIDE);
  localparam int MUX_SPAN    = NUM_BANKS * MUX_WORDS * 4;
  localparam int PULL_SPAN   = NUM_BANKS * PULL_STRIDE;

  localparam logic [ADDR_W-1:0] MUX_BASE_A    = ADDR_W'(MUX_BASE);
  localparam logic [ADDR_W-1:0] PULL_BASE_A   = ADDR_W'(PULL_BASE);
  localparam logic [ADDR_W-1:0] MUX_SPAN_A    = ADDR_W'(MUX_SPAN);
  localparam logic [ADDR_W-1:0] PULL_SPAN_A   = ADDR_W'(PULL_SPAN);
  localparam logic [ADDR_W-1:0] PULL_STRIDE_A = ADDR_W'(PULL_STRIDE);
  localparam logic [ADDR_W-1:0] PULL_WORDS_A  = ADDR_W'(PULL_WORDS);

  logic [ADDR_W-1:0] muxOff, pullOffs, pullBank, pullSlot;
  logic              muxHit, pullHit;

  always_comb begin
    muxOff   = addr - MUX_BASE_A;
    pullOffs = addr - PULL_BASE_A;
    pullBank = pullOffs >> STRIDE_SH;
    pullSlot = (pullOffs & (PULL_STRIDE_A - 1'b1)) >> 2;
    muxHit   = (addr >= MUX_BASE_A) && (muxOff < MUX_SPAN_A);
    pullHit  = (addr >= PULL_BASE_A) && (pullOffs < PULL_SPAN_A)
               && (pullSlot < PULL_WORDS_A);
    strb.rdMux  = muxHit;
    strb.rdPull = pullHit;
    strb.wrMux  = muxHit && wrEn;
    strb.wrPull = pullHit && wrEn;
    strb.idx    = muxHit ? IDX_W'(muxOff >> 2)
                         : IDX_W'(pullBank * PULL_WORDS_A + pullSlot);
  end

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdMux, strb.rdPull}));                       // R7
  AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMux || strb.wrPull) |-> wrEn);                      // R8
endmodule

// File: rtl/pinregs_store.sv
module pinregs_store
  import pinregs_pkg::*;
#(
  parameter int NUM_MUX_WORDS  = 16,
  parameter int NUM_PULL_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobe_t                    strb,
  input  logic [31:0]                   wrData,
  output logic [31:0]                   rdData,
  output logic [NUM_MUX_WORDS*16-1:0]   muxFlat,
  output logic [NUM_PULL_WORDS*16-1:0]  pullFlat
);
  logic [15:0] wrMask, wrVal, rdWord;
  logic [15:0] muxWords  [NUM_MUX_WORDS];
  logic [15:0] pullWords [NUM_PULL_WORDS];

  assign wrMask = wrData[31:16];
  assign wrVal  = wrData[15:0];

  for (genvar w = 0; w < NUM_MUX_WORDS; w++) begin : g_mux
    always_ff @(posedge clk) begin
      if (!rstN)
        muxWords[w] <= '0;
      else if (strb.wrMux && strb.idx == IDX_W'(w))
        muxWords[w] <= (muxWords[w] & ~wrMask) | (wrVal & wrMask);
    end
    assign muxFlat[w*16 +: 16] = muxWords[w];

    AST_MUX_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrMux && strb.idx == IDX_W'(w)) |=>
      ((muxWords[w] ^ $past(muxWords[w])) & ~$past(wrMask)) == 16'h0); // R1
    AST_MUX_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrMux && strb.idx == IDX_W'(w)) |=>
      (muxWords[w] & $past(wrMask)) == ($past(wrVal) & $past(wrMask))); // R1
    AST_MUX_NO_STRAY: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrMux && strb.idx == IDX_W'(w)) |=> $stable(muxWords[w])); // R7
  end

  for (genvar w = 0; w < NUM_PULL_WORDS; w++) begin : g_pull
    always_ff @(posedge clk) begin
      if (!rstN)
        pullWords[w] <= '0;
      else if (strb.wrPull && strb.idx == IDX_W'(w))
        pullWords[w] <= (pullWords[w] & ~wrMask) | (wrVal & wrMask);
    end
    assign pullFlat[w*16 +: 16] = pullWords[w];

    AST_PULL_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrPull && strb.idx == IDX_W'(w)) |=>
      ((pullWords[w] ^ $past(pullWords[w])) & ~$past(wrMask)) == 16'h0); // R1
    AST_PULL_NO_STRAY: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrPull && strb.idx == IDX_W'(w)) |=> $stable(pullWords[w])); // R7
  end

  always_comb begin
    rdWord = '0;
    for (int w = 0; w < NUM_MUX_WORDS; w++)
      if (strb.rdMux && strb.idx == IDX_W'(w)) rdWord = rdWord | muxWords[w];
    for (int w = 0; w < NUM_PULL_WORDS; w++)
      if (strb.rdPull && strb.idx == IDX_W'(w)) rdWord = rdWord | pullWords[w];
    rdData = {16'h0000, rdWord};
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:16] == 16'h0);                                    // R5
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdMux || strb.rdPull) |-> rdData == 32'h0);          // R7
endmodule

// File: rtl/pinmux_pull_regs.sv
module pinmux_pull_regs
  import pinregs_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int MUX_BASE      = 'h0A8,
  parameter int PULL_LAYOUT   = 0
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                wrEn,
  input  logic [31:0]                         wrData,
  output logic [31:0]                         rdData,
  output logic [NUM_BANKS*PINS_PER_BANK*2-1:0] muxSel,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pullOff
);
  localparam int MUX_WORDS  = PINS_PER_BANK / 8;
  localparam int PULL_WORDS = PINS_PER_BANK / 16;

  regStrobe_t strb;

  pinregs_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .MUX_WORDS(MUX_WORDS),
    .PULL_WORDS(PULL_WORDS), .MUX_BASE(MUX_BASE), .PULL_LAYOUT(PULL_LAYOUT)
  ) u_decode (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .strb(strb)
  );

  pinregs_store #(
    .NUM_MUX_WORDS(NUM_BANKS * MUX_WORDS),
    .NUM_PULL_WORDS(NUM_BANKS * PULL_WORDS)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .muxFlat(muxSel), .pullFlat(pullOff)
  );
endmodule

// File: tb/pinmux_pull_regs_bench.sv
module pinmux_pull_regs_bench;
  localparam int NB = 4;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] addr = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataAlt;
  logic [NB*NP*2-1:0] muxSel, muxSelAlt;
  logic [NB*NP-1:0] pullOff, pullOffAlt;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdlMux [NB*4];
  logic [15:0] mdlPull [NB*2];

  always #2 clk = ~clk;

  pinmux_pull_regs u_pinmux_pull_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .muxSel(muxSel), .pullOff(pullOff));

  pinmux_pull_regs #(.PULL_LAYOUT(1)) u_pinmux_pull_regs_alt (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdDataAlt), .muxSel(muxSelAlt), .pullOff(pullOffAlt));

  task automatic check(input logic ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [31:0] d);
    return (o & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  task automatic writeMux(input int b, input int k, input logic [31:0] d);
    doWrite(12'(32'h0A8 + b*16 + k*4), d);
    mdlMux[b*4+k] = merge(mdlMux[b*4+k], d);
  endtask

  task automatic writePull(input int b, input int k, input logic [31:0] d);
    doWrite(12'(32'h118 + b*8 + k*4), d);
    mdlPull[b*2+k] = merge(mdlPull[b*2+k], d);
  endtask

  task automatic readCheck(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(rdData === exp, tag, 256'(rdData), 256'(exp));
  endtask

  // Expected pad outputs from the pin-to-field rules of R2 and R3
  task automatic checkOutputs(input string tag);
    logic [NB*NP*2-1:0] expMux;
    logic [NB*NP-1:0] expPull;
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++) begin
        expMux[(b*NP+p)*2 +: 2] = mdlMux[b*4 + p/8][2*(p%8) +: 2];
        expPull[b*NP+p] = mdlPull[b*2 + p/16][p%16];
      end
    check(muxSel === expMux, {tag, " muxSel"}, 256'(muxSel), 256'(expMux));
    check(pullOff === expPull, {tag, " pullOff"}, 256'(pullOff), 256'(expPull));
  endtask

  task automatic testReset();
    for (int i = 0; i < NB*4; i++) mdlMux[i] = '0;
    for (int i = 0; i < NB*2; i++) mdlPull[i] = '0;
    checkOutputs("R6 reset");
    readCheck(12'h0A8, 32'h0, "R6 reset mux read");
    check(pullOffAlt === '0, "R6 reset alt pull", 256'(pullOffAlt), 256'(0));
  endtask

  task automatic testMuxField();
    // bank 2 pin 13: word 1, bits [11:10], code 3
    writeMux(2, 1, 32'h0C00_0C00);
    check(muxSel[(2*NP+13)*2 +: 2] === 2'd3, "R2 bank2 pin13",
          256'(muxSel[(2*NP+13)*2 +: 2]), 256'(3));
    checkOutputs("R2 single field");
    writeMux(0, 3, 32'h0003_0002);   // bank 0 pin 24 code 2
    checkOutputs("R2 bank0 pin24");
  endtask

  task automatic testMasking();
    writeMux(1, 2, 32'hFFFF_AAAA);
    writeMux(1, 2, 32'h00F0_0050);
    readCheck(12'h0A8 + 12'h018, 32'h0000_AA5A, "R1 partial mask");
    writeMux(1, 2, 32'h0000_FFFF);
    readCheck(12'h0A8 + 12'h018, 32'h0000_AA5A, "R1 empty mask");
    checkOutputs("R1 outputs");
  endtask

  task automatic testPull();
    // bank 3 pin 20: word 1, bit 4
    writePull(3, 1, 32'h0010_0010);
    check(pullOff[3*NP+20] === 1'b1, "R3 bank3 pin20", 256'(pullOff[3*NP+20]), 256'(1));
    readCheck(12'h134, 32'h0000_0010, "R5 pull read upper zero");
    writePull(0, 0, 32'h8001_8001);
    checkOutputs("R3 pull outputs");
  endtask

  task automatic testOutside();
    doWrite(12'h200, 32'hFFFF_FFFF);
    doWrite(12'h110, 32'hFFFF_FFFF);   // gap below the pull region
    doWrite(12'h0A4, 32'hFFFF_FFFF);   // just below the mux region
    checkOutputs("R7 ignored writes");
    readCheck(12'h200, 32'h0, "R7 outside read");
    readCheck(12'h138, 32'h0, "R7 past pull end read");
  endtask

  task automatic testAltLayout();
    // layout 1: bank 1 word 1 at 0x164+0x10+4 = 0x178, bit 0 -> pin 48
    doWrite(12'h178, 32'h0001_0001);
    check(pullOffAlt[1*NP+16] === 1'b1, "R4 alt bank1 pin16",
          256'(pullOffAlt[1*NP+16]), 256'(1));
    doWrite(12'h16C, 32'hFFFF_FFFF);   // unused slot of bank 0
    check(pullOffAlt === 128'(1) << (NP+16), "R4 alt unused slot ignored",
          256'(pullOffAlt), 256'(128'(1) << (NP+16)));
    @(negedge clk); addr = 12'h16C; #1;
    check(rdDataAlt === 32'h0, "R4 alt unused slot read", 256'(rdDataAlt), 256'(0));
    addr = 12'h178; #1;
    check(rdDataAlt === 32'h1, "R4 alt read", 256'(rdDataAlt), 256'(1));
    check(pullOff[1*NP+16] === 1'b0, "R4 default layout untouched",
          256'(pullOff[1*NP+16]), 256'(0));
  endtask

  task automatic testTiming();
    @(negedge clk);
    addr = 12'h0A8; wrData = 32'h0003_0001; wrEn = 1'b1;
    #1;
    check(muxSel[1:0] === 2'd0, "R8 before edge", 256'(muxSel[1:0]), 256'(0));
    @(posedge clk); #1;
    check(muxSel[1:0] === 2'd1, "R8 after edge", 256'(muxSel[1:0]), 256'(1));
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    mdlMux[0] = merge(mdlMux[0], 32'h0003_0001);
    checkOutputs("R8 outputs");
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    testReset();
    testMuxField();
    testMasking();
    testPull();
    testOutside();
    testAltLayout();
    testTiming();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finishRun();
  end
endmodule